// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This block sits next to a simple processor core and decides, each cycle, whether control must leave the current instruction stream. It weighs five synchronous fault causes from the pipeline against eight external interrupt lines. When something wins, it forms the handler address from a table of 16-byte slots and asks the core to redirect. In the same cycle it records the state the handler needs to resume: the interrupted PC, the old interrupt level and, for memory faults, the failing address with a reason code.

A fault aborts the instruction that raised it, so a fault is taken in any cycle. An interrupt is only taken when the core reports that an instruction has retired. Interrupt line 0 cannot be masked. Lines 1 to 7 are gated by a small level field that entry clears, which leaves the handler uninterruptible. Software reaches the saved state, the level fields and a scratch word through one special-register port. A return strobe sends the core back to the saved PC and restores the level.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the saved PC, scratch word, fault record and both level fields read zero. The first cycle after reset is released redirects to address 0x00 with cause 0.
- R2: Fault inputs map to cause index = bit + 1, giving vector = index × 16. Bit 0 (bus) goes to 0x10, bit 1 (instruction) to 0x20, bit 2 (privilege) to 0x30, bit 3 (MMU) to 0x40 and bit 4 (coprocessor) to 0x50. A fault is taken whatever the level and whether or not an instruction retires. Among several faults the lowest bit wins.
- R3: Interrupt line n maps to cause index 8 + n and vector 0x80 + 0x10·n.
- R4: Line 0 is taken at any level, including level zero. Any pending fault takes precedence over every interrupt line.
- R5: Line n (1..7) is accepted only when n ≤ level[2:0]. When several accepted lines are raised, the lowest-numbered one wins. Levels 0, 1, 3 and 7 must mask accordingly.
- R6: No interrupt line is taken in a cycle where insn_done_i is low.
- R7: On entry, the saved PC takes pc_i, the prior field takes the old level and the level becomes zero. An interrupt entry raises exactly one acknowledge bit, the bit of the line taken.
- R8: On a bus or MMU fault entry, the fault record becomes {fault_addr_i[31:2], fault_cause_i[1:0]}. Every other entry leaves it unchanged.
- R9: Entry never alters the scratch word. Software writes to it and reads it through selector 1.
- R10: The special-register selector codes are 0 saved PC, 1 scratch, 2 fault record and 3 status. The status word holds the level in bits 3:0 and the prior level in bits 7:4. Reads are combinational and writes take effect at the next edge. An entry in the same cycle overrides a software write to the saved PC, status or fault record.
- R11: A return strobe redirects to the saved PC in the same cycle and copies prior into level at the edge. It is ignored when an entry is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 5 | Fault causes: bus, instruction, privilege, MMU, coprocessor |
| irq_i | input | 8 | External interrupt lines, 0 non-maskable |
| insn_done_i | input | 1 | Current instruction retires this cycle |
| pc_i | input | 32 | PC to save on entry |
| fault_addr_i | input | 32 | Failing memory address |
| fault_cause_i | input | 2 | Memory fault reason code |
| rtt_i | input | 1 | Return-from-trap strobe |
| sr_we_i | input | 1 | Special-register write enable |
| sr_sel_i | input | 2 | Special-register selector |
| sr_wdata_i | input | 32 | Special-register write data |
| sr_rdata_o | output | 32 | Special-register read data |
| take_o | output | 1 | Entry taken this cycle |
| cause_o | output | 4 | Cause index of the entry |
| irq_ack_o | output | 8 | One-hot acknowledge of the interrupt taken |
| redirect_valid_o | output | 1 | Core must load redirect_pc_o |
| redirect_pc_o | output | 32 | Handler vector or return address |
| psw_level_o | output | 4 | Current interrupt level field |
| psw_prior_o | output | 4 | Saved prior level field |

## Verification
A corrupted level field shows at the ports in the same cycle, as an interrupt line accepted or refused against R5. It also shows one edge after entry, as a nonzero status readback. A wrong saved PC or prior field first becomes visible on the next return strobe, where the redirect address or the restored level is wrong. It can also be seen at once by reading selector 0 or 3. A wrong fault record or scratch word shows only on a readback, so the bench reads each one right after the entry that could have changed it.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int unsigned IDX_W = 4;

   localparam logic [IDX_W-1:0] IDX_RESET = 4'd0;
   localparam logic [IDX_W-1:0] IDX_BUS   = 4'd1;
   localparam logic [IDX_W-1:0] IDX_MMU   = 4'd4;
   localparam logic [IDX_W-1:0] IDX_IRQ0  = 4'd8;

   typedef enum logic [1:0] {
      SR_TPC = 2'd0,
      SR_TSV = 2'd1,
      SR_TMA = 2'd2,
      SR_PSW = 2'd3
   } sr_sel_e;

   typedef struct packed {
      logic             take;
      logic             mem_fault;
      logic [IDX_W-1:0] idx;
   } entry_t;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int unsigned NUM_TRAP = 5,
   parameter int unsigned NUM_IRQ  = 8
) (
   input  logic                boot_pend,
   input  logic [NUM_TRAP-1:0] trap_req,
   input  logic [NUM_IRQ-1:0]  irq,
   input  logic                insn_done,
   input  logic [2:0]          level3,
   output entry_t              entry,
   output logic [NUM_IRQ-1:0]  irq_ack
);

   localparam int unsigned IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   logic [NUM_IRQ-1:0] irq_en;
   logic [NUM_IRQ-1:0] irq_live;
   logic [IDX_W-1:0]   trap_idx;
   logic [IRQ_IW-1:0]  irq_n;

   // per-line enable against the level field
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_en
      if (g == 0) begin : g_nmi
         assign irq_en[g] = 1'b1;
      end else begin : g_mask
         assign irq_en[g] = (3'(g) <= level3);
      end
   end

   assign irq_live = irq & irq_en & {NUM_IRQ{insn_done}};

   // lowest set bit wins in both encoders
   always_comb begin
      trap_idx = IDX_RESET;
      for (int i = NUM_TRAP - 1; i >= 0; i--) begin
         if (trap_req[i]) trap_idx = IDX_W'(i + 1);
      end
   end

   always_comb begin
      irq_n = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (irq_live[i]) irq_n = IRQ_IW'(i);
      end
   end

   always_comb begin
      entry   = '0;
      irq_ack = '0;
      if (boot_pend) begin
         entry.take = 1'b1;
         entry.idx  = IDX_RESET;
      end else if (|trap_req) begin
         entry.take      = 1'b1;
         entry.idx       = trap_idx;
         entry.mem_fault = (trap_idx == IDX_BUS) || (trap_idx == IDX_MMU);
      end else if (|irq_live) begin
         entry.take     = 1'b1;
         entry.idx      = IDX_IRQ0 + IDX_W'(irq_n);
         irq_ack[irq_n] = 1'b1;
      end
   end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
   parameter int unsigned     XLEN       = 32,
   parameter logic [XLEN-1:0] VEC_BASE   = '0,
   parameter int unsigned     SLOT_SHIFT = 4
) (
   input  logic [3:0]      idx,
   output logic [XLEN-1:0] vector
);

   localparam int unsigned SPAN_W  = SLOT_SHIFT + 4;
   localparam bit          ALIGNED = (VEC_BASE[SPAN_W-1:0] == '0);

   if (ALIGNED) begin : g_concat
      assign vector = {VEC_BASE[XLEN-1:SPAN_W], idx, {SLOT_SHIFT{1'b0}}};
   end else begin : g_add
      assign vector = VEC_BASE + (XLEN'(idx) << SLOT_SHIFT);
   end

endmodule

// File: rtl/trap_sr_file.sv
module trap_sr_file
   import trap_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned LVL_W = 4,
   parameter int unsigned FC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_take,
   input  logic              ent_mem,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-FC_W-1:0] fault_hi,
   input  logic [FC_W-1:0]   fault_cause,
   input  logic              rtt,
   input  logic              sr_we,
   input  logic [1:0]        sr_sel,
   input  logic [XLEN-1:0]   sr_wdata,
   output logic [XLEN-1:0]   sr_rdata,
   output logic [XLEN-1:0]   tpc,
   output logic [XLEN-1:0]   tsv,
   output logic [LVL_W-1:0]  level,
   output logic [LVL_W-1:0]  prior
);

   localparam int unsigned PAD_W = XLEN - 2 * LVL_W;

   logic [XLEN-1:0]  tpc_q, tsv_q, tma_q;
   logic [LVL_W-1:0] lvl_q, pri_q;
   sr_sel_e          sel;

   assign sel = sr_sel_e'(sr_sel);

   // later assignments win: software, then return, then entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpc_q <= '0;
         tsv_q <= '0;
         tma_q <= '0;
         lvl_q <= '0;
         pri_q <= '0;
      end else begin
         if (sr_we) begin
            unique case (sel)
               SR_TPC: tpc_q <= sr_wdata;
               SR_TSV: tsv_q <= sr_wdata;
               SR_TMA: tma_q <= sr_wdata;
               SR_PSW: begin
                  lvl_q <= sr_wdata[LVL_W-1:0];
                  pri_q <= sr_wdata[2*LVL_W-1:LVL_W];
               end
               default: ;
            endcase
         end
         if (rtt && !ent_take) begin
            lvl_q <= pri_q;
         end
         if (ent_take) begin
            tpc_q <= pc;
            pri_q <= lvl_q;
            lvl_q <= '0;
            if (ent_mem) tma_q <= {fault_hi, fault_cause};
         end
      end
   end

   always_comb begin
      unique case (sel)
         SR_TPC:  sr_rdata = tpc_q;
         SR_TSV:  sr_rdata = tsv_q;
         SR_TMA:  sr_rdata = tma_q;
         SR_PSW:  sr_rdata = {{PAD_W{1'b0}}, pri_q, lvl_q};
         default: sr_rdata = '0;
      endcase
   end

   assign tpc   = tpc_q;
   assign tsv   = tsv_q;
   assign level = lvl_q;
   assign prior = pri_q;

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     NUM_TRAP   = 5,
   parameter int unsigned     NUM_IRQ    = 8,
   parameter int unsigned     LVL_W      = 4,
   parameter int unsigned     FC_W       = 2,
   parameter int unsigned     SLOT_SHIFT = 4,
   parameter logic [XLEN-1:0] VEC_BASE   = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRAP-1:0] trap_req_i,
   input  logic [NUM_IRQ-1:0]  irq_i,
   input  logic                insn_done_i,
   input  logic [XLEN-1:0]     pc_i,
   input  logic [XLEN-1:0]     fault_addr_i,
   input  logic [FC_W-1:0]     fault_cause_i,
   input  logic                rtt_i,
   input  logic                sr_we_i,
   input  logic [1:0]          sr_sel_i,
   input  logic [XLEN-1:0]     sr_wdata_i,
   output logic [XLEN-1:0]     sr_rdata_o,
   output logic                take_o,
   output logic [IDX_W-1:0]    cause_o,
   output logic [NUM_IRQ-1:0]  irq_ack_o,
   output logic                redirect_valid_o,
   output logic [XLEN-1:0]     redirect_pc_o,
   output logic [LVL_W-1:0]    psw_level_o,
   output logic [LVL_W-1:0]    psw_prior_o
);

   // elaboration-time parameter checks
   if (NUM_TRAP < 1 || NUM_TRAP > 7) begin : g_bad_trap
      $error("NUM_TRAP must lie in 1..7");
   end
   if (NUM_IRQ < 2 || NUM_IRQ > 8) begin : g_bad_irq
      $error("NUM_IRQ must lie in 2..8");
   end
   if (LVL_W < 3 || 2 * LVL_W >= XLEN) begin : g_bad_lvl
      $error("LVL_W must be at least 3 and fit twice in XLEN");
   end
   if (FC_W < 1 || FC_W >= XLEN) begin : g_bad_fc
      $error("FC_W out of range");
   end
   if (SLOT_SHIFT < 2 || SLOT_SHIFT + 4 > XLEN) begin : g_bad_slot
      $error("SLOT_SHIFT out of range");
   end

   logic             boot_pend;
   entry_t           entry;
   logic [XLEN-1:0]  vector;
   logic [XLEN-1:0]  tpc_w, tsv_w;
   logic [LVL_W-1:0] lvl_w, pri_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         boot_pend <= 1'b1;
      else if (boot_pend) boot_pend <= 1'b0;
   end

   trap_arbiter #(
      .NUM_TRAP (NUM_TRAP),
      .NUM_IRQ  (NUM_IRQ)
   ) u_arb (
      .boot_pend (boot_pend),
      .trap_req  (trap_req_i),
      .irq       (irq_i),
      .insn_done (insn_done_i),
      .level3    (lvl_w[2:0]),
      .entry     (entry),
      .irq_ack   (irq_ack_o)
   );

   trap_vector_gen #(
      .XLEN       (XLEN),
      .VEC_BASE   (VEC_BASE),
      .SLOT_SHIFT (SLOT_SHIFT)
   ) u_vec (
      .idx    (entry.idx),
      .vector (vector)
   );

   trap_sr_file #(
      .XLEN  (XLEN),
      .LVL_W (LVL_W),
      .FC_W  (FC_W)
   ) u_sr (
      .clk         (clk),
      .rst_n       (rst_n),
      .ent_take    (entry.take),
      .ent_mem     (entry.mem_fault),
      .pc          (pc_i),
      .fault_hi    (fault_addr_i[XLEN-1:FC_W]),
      .fault_cause (fault_cause_i),
      .rtt         (rtt_i),
      .sr_we       (sr_we_i),
      .sr_sel      (sr_sel_i),
      .sr_wdata    (sr_wdata_i),
      .sr_rdata    (sr_rdata_o),
      .tpc         (tpc_w),
      .tsv         (tsv_w),
      .level       (lvl_w),
      .prior       (pri_w)
   );

   assign take_o           = entry.take;
   assign cause_o          = entry.idx;
   assign redirect_valid_o = entry.take | rtt_i;
   assign redirect_pc_o    = entry.take ? vector : tpc_w;
   assign psw_level_o      = lvl_w;
   assign psw_prior_o      = pri_w;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NUM_TRAP = 5,
   parameter int unsigned NUM_IRQ  = 8,
   parameter int unsigned LVL_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_TRAP-1:0] trap_req_i,
   input logic                insn_done_i,
   input logic [XLEN-1:0]     pc_i,
   input logic                rtt_i,
   input logic                sr_we_i,
   input logic [1:0]          sr_sel_i,
   input logic                take_o,
   input logic [NUM_IRQ-1:0]  irq_ack_o,
   input logic                redirect_valid_o,
   input logic [XLEN-1:0]     redirect_pc_o,
   input logic [LVL_W-1:0]    psw_level_o,
   input logic [LVL_W-1:0]    psw_prior_o,
   input logic [XLEN-1:0]     tpc,
   input logic [XLEN-1:0]     tsv
);

   // R7
   entry_level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> psw_level_o == '0);

   // R7
   entry_prior_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> psw_prior_o == $past(psw_level_o));

   // R7
   entry_pc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> tpc == $past(pc_i));

   // R7
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack_o) && ((|irq_ack_o) -> take_o));

   // R4
   trap_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|trap_req_i) |-> irq_ack_o == '0);

   // R6
   irq_waits_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done_i |-> irq_ack_o == '0);

   // R5
   for (genvar g = 1; g < NUM_IRQ; g++) begin : g_mask
      irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_ack_o[g] |-> psw_level_o[2:0] >= 3'(g));
   end

   // R9
   tsv_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && !(sr_we_i && sr_sel_i == 2'd1) |=> $stable(tsv));

   // R11
   rtt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rtt_i && !take_o |-> redirect_valid_o && redirect_pc_o == tpc);

   // R11
   rtt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rtt_i && !take_o |=> psw_level_o == $past(psw_prior_o));

endmodule

bind trap_entry_ctrl trap_entry_chk #(
   .XLEN     (XLEN),
   .NUM_TRAP (NUM_TRAP),
   .NUM_IRQ  (NUM_IRQ),
   .LVL_W    (LVL_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .trap_req_i       (trap_req_i),
   .insn_done_i      (insn_done_i),
   .pc_i             (pc_i),
   .rtt_i            (rtt_i),
   .sr_we_i          (sr_we_i),
   .sr_sel_i         (sr_sel_i),
   .take_o           (take_o),
   .irq_ack_o        (irq_ack_o),
   .redirect_valid_o (redirect_valid_o),
   .redirect_pc_o    (redirect_pc_o),
   .psw_level_o      (psw_level_o),
   .psw_prior_o      (psw_prior_o),
   .tpc              (tpc_w),
   .tsv              (tsv_w)
);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  trap_req_i;
   logic [7:0]  irq_i;
   logic        insn_done_i;
   logic [31:0] pc_i;
   logic [31:0] fault_addr_i;
   logic [1:0]  fault_cause_i;
   logic        rtt_i;
   logic        sr_we_i;
   logic [1:0]  sr_sel_i;
   logic [31:0] sr_wdata_i;
   logic [31:0] sr_rdata_o;
   logic        take_o;
   logic [3:0]  cause_o;
   logic [7:0]  irq_ack_o;
   logic        redirect_valid_o;
   logic [31:0] redirect_pc_o;
   logic [3:0]  psw_level_o;
   logic [3:0]  psw_prior_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   localparam logic [1:0] S_TPC = 2'd0, S_TSV = 2'd1, S_TMA = 2'd2, S_PSW = 2'd3;

   always #5 clk = ~clk;

   trap_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req_i), .irq_i(irq_i),
      .insn_done_i(insn_done_i), .pc_i(pc_i), .fault_addr_i(fault_addr_i),
      .fault_cause_i(fault_cause_i), .rtt_i(rtt_i), .sr_we_i(sr_we_i),
      .sr_sel_i(sr_sel_i), .sr_wdata_i(sr_wdata_i), .sr_rdata_o(sr_rdata_o),
      .take_o(take_o), .cause_o(cause_o), .irq_ack_o(irq_ack_o),
      .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
      .psw_level_o(psw_level_o), .psw_prior_o(psw_prior_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] v);
      sr_sel_i = sel;
      #1 v = sr_rdata_o;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      sr_we_i = 1'b1; sr_sel_i = sel; sr_wdata_i = d;
      @(negedge clk);
      sr_we_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rst_n = 1'b0;
      trap_req_i = '0; irq_i = '0; insn_done_i = 1'b0; pc_i = '0;
      fault_addr_i = '0; fault_cause_i = '0; rtt_i = 1'b0;
      sr_we_i = 1'b0; sr_sel_i = '0; sr_wdata_i = '0;
      repeat (3) @(negedge clk);
      rd(S_PSW, v); chk("R1", "status after reset", v, 32'h0);
      rd(S_TPC, v); chk("R1", "saved pc after reset", v, 32'h0);
      rd(S_TSV, v); chk("R1", "scratch after reset", v, 32'h0);
      rd(S_TMA, v); chk("R1", "fault record after reset", v, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "boot take", {31'b0, take_o}, 32'h1);
      chk("R1", "boot cause", {28'b0, cause_o}, 32'h0);
      chk("R1", "boot vector", redirect_pc_o, 32'h0);
      @(negedge clk); #1;
      chk("R1", "idle after boot", {31'b0, take_o}, 32'h0);
   endtask

   task automatic t_traps();
      logic [31:0] v;
      for (int k = 0; k < 5; k++) begin
         wr(S_PSW, 32'h07);
         pc_i = 32'h1000 + 32'(k * 4);
         trap_req_i = 5'(1 << k); insn_done_i = 1'b0;
         #1;
         chk("R2", "trap take", {31'b0, take_o}, 32'h1);
         chk("R2", "trap vector", redirect_pc_o, 32'(16 * (k + 1)));
         @(negedge clk);
         trap_req_i = '0;
         rd(S_PSW, v); chk("R7", "status after trap", v, 32'h70);
         rd(S_TPC, v); chk("R7", "saved pc after trap", v, 32'h1000 + 32'(k * 4));
      end
      // several faults plus line 0: lowest fault bit wins
      @(negedge clk);
      trap_req_i = 5'b10110; irq_i = 8'h01; insn_done_i = 1'b1;
      #1;
      chk("R2", "multi-fault cause", {28'b0, cause_o}, 32'h2);
      chk("R4", "fault beats line 0 ack", {24'b0, irq_ack_o}, 32'h0);
      @(negedge clk);
      trap_req_i = '0; irq_i = '0;
      // fault record capture
      fault_addr_i = 32'h1234_5678; fault_cause_i = 2'b10; trap_req_i = 5'b00001;
      @(negedge clk);
      trap_req_i = '0;
      rd(S_TMA, v); chk("R8", "record on bus fault", v, 32'h1234_567A);
      @(negedge clk);
      fault_addr_i = 32'h5555_0000; fault_cause_i = 2'b11; trap_req_i = 5'b00010;
      @(negedge clk);
      trap_req_i = '0;
      rd(S_TMA, v); chk("R8", "record kept on insn fault", v, 32'h1234_567A);
      @(negedge clk);
      fault_addr_i = 32'hABCD_0000; fault_cause_i = 2'b01; trap_req_i = 5'b01000;
      @(negedge clk);
      trap_req_i = '0; insn_done_i = 1'b0;
      rd(S_TMA, v); chk("R8", "record on MMU fault", v, 32'hABCD_0001);
   endtask

   task automatic t_irq0();
      wr(S_PSW, 32'h0);
      irq_i = 8'h01; insn_done_i = 1'b0;
      #1 chk("R6", "no take before retire", {31'b0, take_o}, 32'h0);
      insn_done_i = 1'b1;
      #1;
      chk("R4", "line 0 at level 0", {31'b0, take_o}, 32'h1);
      chk("R3", "line 0 vector", redirect_pc_o, 32'h80);
      chk("R7", "line 0 ack", {24'b0, irq_ack_o}, 32'h01);
      @(negedge clk);
      irq_i = '0; insn_done_i = 1'b0;
   endtask

   task automatic t_mask();
      logic [31:0] v;
      logic [3:0]  lv [4] = '{4'd0, 4'd1, 4'd3, 4'd7};
      for (int j = 0; j < 4; j++) begin
         wr(S_PSW, {28'b0, lv[j]});
         for (int n = 1; n < 8; n++) begin
            @(negedge clk);
            irq_i = 8'(1 << n); insn_done_i = 1'b1;
            #1;
            if (n <= int'(lv[j])) begin
               chk("R5", "enabled line taken", {31'b0, take_o}, 32'h1);
               chk("R3", "line vector", redirect_pc_o, 32'h80 + 32'(16 * n));
            end else begin
               chk("R5", "masked line refused", {31'b0, take_o}, 32'h0);
            end
            irq_i = '0; insn_done_i = 1'b0;
            if (n <= int'(lv[j])) begin
               wr(S_PSW, {28'b0, lv[j]});
            end
         end
      end
      wr(S_PSW, 32'h07);
      irq_i = 8'hA8; insn_done_i = 1'b1;
      #1;
      chk("R5", "lowest line wins", {28'b0, cause_o}, 32'hB);
      chk("R7", "single ack", {24'b0, irq_ack_o}, 32'h08);
      @(negedge clk);
      irq_i = '0; insn_done_i = 1'b0;
      rd(S_PSW, v); chk("R7", "status after interrupt", v, 32'h70);
   endtask

   task automatic t_scratch();
      logic [31:0] v;
      wr(S_TSV, 32'hCAFE_F00D);
      rd(S_TSV, v); chk("R9", "scratch readback", v, 32'hCAFE_F00D);
      trap_req_i = 5'b00001;
      @(negedge clk);
      trap_req_i = '0;
      rd(S_TSV, v); chk("R9", "scratch kept over entry", v, 32'hCAFE_F00D);
      @(negedge clk);
      sr_we_i = 1'b1; sr_sel_i = S_TPC; sr_wdata_i = 32'hDEAD_0000;
      trap_req_i = 5'b00010; pc_i = 32'h2222;
      @(negedge clk);
      sr_we_i = 1'b0; trap_req_i = '0;
      rd(S_TPC, v); chk("R10", "entry overrides write", v, 32'h2222);
   endtask

   task automatic t_rtt();
      logic [31:0] v;
      wr(S_TPC, 32'h4440);
      wr(S_PSW, 32'h30);
      rtt_i = 1'b1;
      #1;
      chk("R11", "return redirect", {31'b0, redirect_valid_o}, 32'h1);
      chk("R11", "return address", redirect_pc_o, 32'h4440);
      @(negedge clk);
      rtt_i = 1'b0;
      rd(S_PSW, v); chk("R11", "level restored", v, 32'h33);
      wr(S_PSW, 32'h50);
      rtt_i = 1'b1; trap_req_i = 5'b00100; pc_i = 32'h7777;
      #1 chk("R11", "entry beats return", redirect_pc_o, 32'h30);
      @(negedge clk);
      rtt_i = 1'b0; trap_req_i = '0;
      rd(S_PSW, v); chk("R11", "return ignored status", v, 32'h00);
      rd(S_TPC, v); chk("R11", "return ignored saved pc", v, 32'h7777);
   endtask

   initial begin
      t_reset();
      t_traps();
      t_irq0();
      t_mask();
      t_scratch();
      t_rtt();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule